// File: doc/BRIEF.md
# Carry-less Multiply Execution Unit

This unit executes the three carry-less multiply instructions of the 32-bit bit-manipulation set. A request carries a 32-bit instruction word and the two source operand values, marked by a valid strobe. The unit decodes the word. If it names one of the three carry-less operations, the unit latches the operands and builds the 64-bit carry-less product over 32 cycles, examining one multiplier bit per cycle from bit 0 upward. It then returns the low word, the high word, or the window just below the top bit of the product.

Any word that is not one of the three operations completes on the next clock edge. It raises the illegal flag, returns a zero result and drives no write enable. Every completion is marked by a one-cycle `done` pulse. The pulse carries the destination register index, the two source indices and a write enable, which stays low when the destination is register 0. While a computation is running, `busy` is high and new requests are not accepted.

Top module: `clmul_unit`

## Requirements
- R1: A word is decoded as carry-less when bits [6:0] are 0110011 and bits [31:25] are 0000101. Bits [14:12] then select the operation: 001 for low product, 011 for high product, 010 for reversed window. Every other word, including funct3 000 and 100 to 111, is illegal.
- R2: The low operation returns bits [31:0] of the carry-less product of the two operands, where partial products rs1<<i for each set bit i of rs2 are combined by XOR.
- R3: The high operation returns bits [63:32] of that product, so bit 0 of rs2 has no effect on it.
- R4: The reversed-window operation returns bits [62:31] of that product.
- R5: For a legal request accepted on clock edge E, `done` is high for exactly one cycle after edge E+32. `busy` is high from edge E until that edge and is low whenever `done` is high.
- R6: Operand values and the instruction word are latched at acceptance, so changes on `rs1_val`, `rs2_val` or `insn` during the computation do not change the result.
- R7: A request presented while `busy` is high is ignored. It produces no completion and does not alter the running computation.
- R8: An illegal request completes after the accepting edge with `done`=1, `illegal`=1, `result`=0 and `wr_en`=0.
- R9: At completion, `rd_idx` equals bits [11:7], `rs1_idx` equals bits [19:15] and `rs2_idx` equals bits [24:20] of the accepted word. `wr_en` is high only with `done` on a legal operation whose `rd_idx` is not 0.
- R10: After synchronous reset, `busy`, `done`, `wr_en` and `illegal` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| insn | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand (multiplicand) |
| rs2_val | input | 32 | Second source operand (multiplier) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Selected product word, held until the next completion |
| rd_idx | output | 5 | Destination register index of the completed word |
| rs1_idx | output | 5 | First source index of the completed word |
| rs2_idx | output | 5 | Second source index of the completed word |
| wr_en | output | 1 | Register write request, high only with `done` |
| illegal | output | 1 | Completed word was not a carry-less operation |

## Verification
The bench runs each operation against a full 64-bit reference product, including a zero multiplier, a multiplier of one and all-ones operands. These cases catch a design that lets bit 0 leak into the high word, that shifts the reversed window by one bit, or that stops one bit early. Each legal run measures the latency in cycles, so a counter that is off by one shows up at once. The bench scrambles operands and drives a competing request while the unit is busy; a design that reads live inputs or queues the second request would return a wrong result or an extra completion. Neighbouring funct3 codes, a wrong opcode, a wrong funct7 and a destination of register 0 cover a decoder that is too loose and a write enable that ignores register 0.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int ILEN = 32;
  localparam int REG_IDX_W = 5;

  localparam logic [6:0] OPC_REG_REG = 7'b0110011;
  localparam logic [6:0] F7_CARRYLESS = 7'b0000101;

  localparam logic [2:0] F3_LOW  = 3'b001;
  localparam logic [2:0] F3_HIGH = 3'b011;
  localparam logic [2:0] F3_REV  = 3'b010;

  typedef enum logic [1:0] {
    CL_LOW  = 2'd0,
    CL_HIGH = 2'd1,
    CL_REV  = 2'd2,
    CL_BAD  = 2'd3
  } clm_op_e;

  typedef struct packed {
    clm_op_e               op;
    logic [REG_IDX_W-1:0]  rd;
    logic [REG_IDX_W-1:0]  src1;
    logic [REG_IDX_W-1:0]  src2;
  } clm_dec_t;
endpackage

// File: rtl/clmul_decode.sv
module clmul_decode
  import clmul_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output clm_dec_t        dec
);
  logic is_family;

  always_comb begin
    is_family = (insn[6:0] == OPC_REG_REG) && (insn[31:25] == F7_CARRYLESS);
    dec.rd    = insn[11:7];
    dec.src1  = insn[19:15];
    dec.src2  = insn[24:20];
    dec.op    = CL_BAD;
    if (is_family) begin
      unique case (insn[14:12])
        F3_LOW:  dec.op = CL_LOW;
        F3_HIGH: dec.op = CL_HIGH;
        F3_REV:  dec.op = CL_REV;
        default: dec.op = CL_BAD;
      endcase
    end
  end

  // R1: a legal operation only ever comes from the carry-less opcode/funct7 pair
  always_comb begin
    if (dec.op != CL_BAD)
      assert_decode_family_R1: assert (is_family)
        else $error("R1: legal op decoded outside the carry-less family");
  end
endmodule

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int XLEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic legal,
  output logic accept,
  output logic start,
  output logic step,
  output logic finish,
  output logic busy
);
  localparam int CNT_W = (XLEN > 1) ? $clog2(XLEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(XLEN - 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    accept = req_valid && !busy;
    start  = accept && legal;
    step   = busy;
    finish = busy && (cnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (finish) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  // R5: once started, the unit stays busy until the last multiplier bit
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (rst)
    busy && !finish |=> busy);
  // R5: the last step releases the unit
  assert_busy_release_R5: assert property (@(posedge clk) disable iff (rst)
    finish |=> !busy);
  // R5: a started computation begins its scan at bit 0
  assert_start_count_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && cnt == '0);
  // R7: nothing is accepted while a computation runs
  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !accept);
endmodule

// File: rtl/clmul_datapath.sv
module clmul_datapath
  import clmul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  clm_op_e         op_in,
  input  logic [XLEN-1:0] a_in,
  input  logic [XLEN-1:0] b_in,
  output logic [XLEN-1:0] sel_next
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   mcand;
  logic [PW-1:0]   acc;
  logic [PW-1:0]   acc_next;
  logic [XLEN-1:0] mplr;
  clm_op_e         op_q;

  always_comb begin
    acc_next = mplr[0] ? (acc ^ mcand) : acc;
    unique case (op_q)
      CL_LOW:  sel_next = acc_next[XLEN-1:0];
      CL_HIGH: sel_next = acc_next[PW-1:XLEN];
      CL_REV:  sel_next = acc_next[PW-2:XLEN-1];
      default: sel_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand <= '0;
      acc   <= '0;
      mplr  <= '0;
      op_q  <= CL_LOW;
    end else if (load) begin
      mcand <= {{XLEN{1'b0}}, a_in};
      acc   <= '0;
      mplr  <= b_in;
      op_q  <= op_in;
    end else if (step) begin
      acc   <= acc_next;
      mcand <= mcand << 1;
      mplr  <= mplr >> 1;
    end
  end

  // R6: the latched operation code never changes during the scan
  assert_op_latched_R6: assert property (@(posedge clk) disable iff (rst)
    step && !load |=> $stable(op_q));
  // R2: a clear multiplier bit leaves the accumulated product untouched
  assert_zero_bit_R2: assert property (@(posedge clk) disable iff (rst)
    step && !load && !mplr[0] |=> $stable(acc));
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
  import clmul_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [ILEN-1:0]      insn,
  input  logic [XLEN-1:0]      rs1_val,
  input  logic [XLEN-1:0]      rs2_val,
  output logic                 busy,
  output logic                 done,
  output logic [XLEN-1:0]      result,
  output logic [REG_IDX_W-1:0] rd_idx,
  output logic [REG_IDX_W-1:0] rs1_idx,
  output logic [REG_IDX_W-1:0] rs2_idx,
  output logic                 wr_en,
  output logic                 illegal
);
  clm_dec_t        dec;
  clm_dec_t        dec_q;
  logic            accept, start, step, finish;
  logic [XLEN-1:0] sel_next;

  clmul_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  clmul_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .legal     (dec.op != CL_BAD),
    .accept    (accept),
    .start     (start),
    .step      (step),
    .finish    (finish),
    .busy      (busy)
  );

  clmul_datapath #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .step     (step),
    .op_in    (dec.op),
    .a_in     (rs1_val),
    .b_in     (rs2_val),
    .sel_next (sel_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q   <= '0;
      done    <= 1'b0;
      result  <= '0;
      rd_idx  <= '0;
      rs1_idx <= '0;
      rs2_idx <= '0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= 1'b0;
      wr_en   <= 1'b0;
      illegal <= 1'b0;
      if (start) begin
        dec_q <= dec;
      end else if (accept) begin
        done    <= 1'b1;
        illegal <= 1'b1;
        result  <= '0;
        rd_idx  <= dec.rd;
        rs1_idx <= dec.src1;
        rs2_idx <= dec.src2;
      end else if (finish) begin
        done    <= 1'b1;
        result  <= sel_next;
        rd_idx  <= dec_q.rd;
        rs1_idx <= dec_q.src1;
        rs2_idx <= dec_q.src2;
        wr_en   <= (dec_q.rd != '0);
      end
    end
  end

  // R9: a write request only accompanies a legal completion
  assert_wr_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done && !illegal);
  // R9: register 0 never receives a write request
  assert_wr_not_zero_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> rd_idx != '0);
  // R8: an illegal completion carries a zero result
  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> done && result == '0);
  // R5: completion and busy are never high together
  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R8: an illegal word accepted while idle completes on the next edge
  assert_illegal_fast_R8: assert property (@(posedge clk) disable iff (rst)
    accept && !start |=> done && illegal);
endmodule

// File: tb/clmul_unit_test.sv
module clmul_unit_test;
  localparam int XLEN = 32;
  localparam int NV = 8;
  localparam logic [31:0] VA [NV] = '{32'h0000_0000, 32'hC3A5_0F17, 32'h0000_0001,
    32'hA5F0_3C69, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF};
  localparam logic [31:0] VB [NV] = '{32'h9ABC_DEF0, 32'h0000_0000, 32'hB00B_1E55,
    32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h9ABC_DEF0, 32'h0000_0003};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] insn = '0, rs1_val = '0, rs2_val = '0;
  logic busy, done, wr_en, illegal;
  logic [XLEN-1:0] result;
  logic [4:0] rd_idx, rs1_idx, rs2_idx;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  clmul_unit #(.XLEN(XLEN)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .insn(insn),
    .rs1_val(rs1_val), .rs2_val(rs2_val), .busy(busy), .done(done),
    .result(result), .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .wr_en(wr_en), .illegal(illegal)
  );

  function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
      input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2,
      input logic [6:0] opc);
    return {f7, s2, s1, f3, rd, opc};
  endfunction

  function automatic logic [63:0] ref_prod(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] p = '0;
    for (int i = 0; i < 32; i++)
      if (b[i]) p ^= ({32'h0, a} << i);
    return p;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Present one request; leave the caller at the negedge where done is seen.
  task automatic run(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
      input bit hammer, output int lat, output logic busy1);
    @(negedge clk);
    insn = w; rs1_val = a; rs2_val = b; req_valid = 1'b1;
    @(negedge clk);
    busy1 = busy;
    if (hammer) begin
      insn = mk(7'b0000101, 3'b011, 5'd9, 5'd1, 5'd2, 7'b0110011);
      rs1_val = 32'h0F0F_F0F0; rs2_val = 32'h7777_7777; req_valid = 1'b1;
    end else begin
      insn = ~w; rs1_val = ~a; rs2_val = b ^ 32'h5A5A_A5A5; req_valid = 1'b0;
    end
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
  endtask

  task automatic legal_case(input logic [2:0] f3, input logic [4:0] rd,
      input logic [31:0] a, input logic [31:0] b, input bit hammer);
    logic [63:0] p = ref_prod(a, b);
    logic [31:0] exp;
    int lat;
    logic b1;
    string tag;
    case (f3)
      3'b001:  begin exp = p[31:0];  tag = "R2 low";  end
      3'b011:  begin exp = p[63:32]; tag = "R3 high"; end
      default: begin exp = p[62:31]; tag = "R4 rev";  end
    endcase
    run(mk(7'b0000101, f3, rd, 5'd11, 5'd22, 7'b0110011), a, b, hammer, lat, b1);
    chk(tag, result, exp);
    chk("R5 latency", lat, 32);
    chk("R5 busy during scan", b1, 1'b1);
    chk("R5 done pulse", done, 1'b1);
    chk("R9 rd_idx", rd_idx, rd);
    chk("R9 src idx", {rs1_idx, rs2_idx}, {5'd11, 5'd22});
    chk("R9 wr_en", wr_en, rd != 5'd0);
    chk("R8 illegal low", illegal, 1'b0);
    @(negedge clk);
    chk("R5 one-cycle done", done, 1'b0);
    chk("R7 no extra start", busy, 1'b0);
  endtask

  task automatic bad_case(input string what, input logic [31:0] w);
    int lat;
    logic b1;
    run(w, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, lat, b1);
    chk({"R1/R8 illegal latency ", what}, lat, 0);
    chk({"R8 illegal flag ", what}, illegal, 1'b1);
    chk({"R8 zero result ", what}, result, 32'h0);
    chk({"R8 no wr_en ", what}, wr_en, 1'b0);
    chk({"R9 rd_idx ", what}, rd_idx, w[11:7]);
    @(negedge clk);
    chk({"R8 no busy ", what}, busy, 1'b0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 reset busy", busy, 1'b0);
    chk("R10 reset done", done, 1'b0);
    chk("R10 reset wr_en", wr_en, 1'b0);
    chk("R10 reset illegal", illegal, 1'b0);
    chk("R10 reset result", result, 32'h0);

    // Vector table across all three operations
    for (int v = 0; v < NV; v++) begin
      legal_case(3'b001, 5'((v * 3) % 31 + 1), VA[v], VB[v], 1'b0);
      legal_case(3'b011, 5'((v * 3 + 1) % 31 + 1), VA[v], VB[v], 1'b0);
      legal_case(3'b010, 5'((v * 3 + 2) % 31 + 1), VA[v], VB[v], 1'b0);
    end

    // R7: competing requests held during the scan are dropped
    legal_case(3'b010, 5'd17, 32'hCAFE_F00D, 32'h8421_1248, 1'b1);
    legal_case(3'b001, 5'd3, 32'h0000_FFFF, 32'hFFFF_0000, 1'b1);

    // R9: destination 0 gives a result but no write
    legal_case(3'b011, 5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);

    // R1: neighbouring and foreign encodings
    bad_case("f3=000", mk(7'b0000101, 3'b000, 5'd4, 5'd1, 5'd2, 7'b0110011));
    bad_case("f3=100", mk(7'b0000101, 3'b100, 5'd5, 5'd1, 5'd2, 7'b0110011));
    bad_case("f3=111", mk(7'b0000101, 3'b111, 5'd6, 5'd1, 5'd2, 7'b0110011));
    bad_case("opcode", mk(7'b0000101, 3'b001, 5'd7, 5'd1, 5'd2, 7'b0010011));
    bad_case("funct7", mk(7'b0000001, 3'b001, 5'd8, 5'd1, 5'd2, 7'b0110011));

    // R10: reset in the middle of a scan clears the unit
    @(negedge clk);
    insn = mk(7'b0000101, 3'b001, 5'd1, 5'd1, 5'd2, 7'b0110011);
    rs1_val = 32'h1; rs2_val = 32'h1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 mid-scan reset busy", busy, 1'b0);
    chk("R10 mid-scan reset done", done, 1'b0);
    repeat (35) @(negedge clk);
    chk("R10 no late completion", done, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule